// File: doc/BRIEF.md
# Collision Retry and Backoff Controller

This block decides when a half-duplex Ethernet transmitter may try a frame again after a collision. When a frame starts, it loads a retry budget from a programmable limit. Each collision reported while the transmitter is allowed to send uses up one retry. The block then draws a random wait, counted in slot times, and holds the transmit-permit output low until that wait has run out.

The random wait is a uniform draw from a 16-bit LFSR. Its range grows with the number of retries made so far plus a persistence offset from 0 to 9. A larger offset makes the station yield more readily. When a collision arrives after the budget is exhausted, the block abandons the frame with a one-cycle give-up pulse. A successful transmission also returns the block to its fresh state for the next frame. The slot length is a programmable number of clock cycles.

Top module: `retry_backoff_ctrl`

## Requirements
- R1: After reset, tx_permit_o is 1, give_up_o is 0, and retry_cnt_o, attempts_o and backoff_cnt_o are 0.
- R2: A cycle with sof_i high loads retry_cnt_o from retry_limit_i, clears attempts_o, and ends any wait in progress: backoff_cnt_o becomes 0 and tx_permit_o becomes 1 on the next cycle.
- R3: A collision accepted while tx_permit_o is 1 and retry_cnt_o is nonzero decrements retry_cnt_o and increments attempts_o on the next cycle.
- R4: The wait drawn on an accepted collision lies in [0, 2^e − 1], where e = min(attempts + p, 10), attempts is the updated attempts_o value, and p is persist_i clamped to at most 9.
- R5: tx_permit_o is 0 exactly while backoff_cnt_o is nonzero. backoff_cnt_o falls by one at each slot boundary, so tx_permit_o returns to 1 exactly D·S clock edges after the collision edge, where D is the drawn wait and S is slot_cycles_i.
- R6: A slot_cycles_i value of 0 acts as a slot of one clock cycle.
- R7: A collision accepted while retry_cnt_o is 0 produces a give_up_o pulse one cycle long, reloads retry_cnt_o from retry_limit_i, clears attempts_o, and leaves tx_permit_o at 1.
- R8: A collision reported while tx_permit_o is 0 is ignored: retry_cnt_o and attempts_o do not change, and the countdown goes on uninterrupted.
- R9: A cycle with tx_ok_i high reloads retry_cnt_o from retry_limit_i, clears attempts_o, and ends any wait in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Strobe: a new frame begins |
| coll_i | input | 1 | Strobe: collision seen on the current attempt |
| tx_ok_i | input | 1 | Strobe: frame sent successfully |
| retry_limit_i | input | 16 | Retries allowed for one frame |
| persist_i | input | 4 | Persistence offset, clamped to 9 |
| slot_cycles_i | input | 16 | Clock cycles per slot time |
| tx_permit_o | output | 1 | High when a transmit attempt may begin |
| give_up_o | output | 1 | One-cycle pulse when the frame is abandoned |
| retry_cnt_o | output | 16 | Retries still available |
| attempts_o | output | 16 | Retries made for the current frame |
| backoff_cnt_o | output | 16 | Slot times still to wait |

## Verification
The bench reads each drawn wait from backoff_cnt_o and counts clock edges until permit returns. An off-by-one slot counter, or a zero slot length that wraps, shows up there as a wrong multiple of the draw. It drives the retry budget to zero and checks that give-up fires on the following collision and not on the one before it. A budget compare that is off by one would abandon the frame early or late. It also fires collisions in the middle of a wait and checks that they neither consume retries nor restart the countdown. Repeated draws at high persistence must stay within 1023 and must also exceed the narrow range that a first retry would have without the offset. A design that ignored persistence, or failed to cap the exponent, would break one of those two bounds.

// File: rtl/retry_backoff_pkg.sv
package retry_backoff_pkg;
  localparam int unsigned EXP_CAP     = 10;
  localparam int unsigned PERSIST_CAP = 9;
  localparam int unsigned EXP_W       = $clog2(EXP_CAP + 1);
endpackage

// File: rtl/rb_lfsr.sv
module rb_lfsr #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] state_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= SEED;
    else         q <= (q >> 1) ^ (q[0] ? TAPS : '0);
  end

  assign state_o = q;
endmodule

// File: rtl/rb_retry_ctl.sv
module rb_retry_ctl
  import retry_backoff_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PER_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             coll_i,
  input  logic             tx_ok_i,
  input  logic             idle_i,
  input  logic [CNT_W-1:0] retry_limit_i,
  input  logic [PER_W-1:0] persist_i,
  input  logic [CNT_W-1:0] rand_i,
  output logic             load_o,
  output logic             clear_o,
  output logic [CNT_W-1:0] draw_o,
  output logic             give_up_o,
  output logic [CNT_W-1:0] retry_cnt_o,
  output logic [CNT_W-1:0] attempts_o
);
  logic [CNT_W-1:0] retry_q, att_q, att_inc, mask;
  logic [PER_W-1:0] persist_c;
  logic [CNT_W:0]   exp_sum;
  logic [EXP_W-1:0] exp_c;
  logic             give_q, coll_ok, reset_frame;

  assign reset_frame = sof_i | tx_ok_i;
  assign coll_ok     = coll_i & idle_i & ~reset_frame;

  always_comb begin
    persist_c = (persist_i > PER_W'(PERSIST_CAP)) ? PER_W'(PERSIST_CAP) : persist_i;
    att_inc   = att_q + 1'b1;
    exp_sum   = {1'b0, att_inc} + (CNT_W+1)'(persist_c);
    exp_c     = (exp_sum > (CNT_W+1)'(EXP_CAP)) ? EXP_W'(EXP_CAP) : exp_sum[EXP_W-1:0];
    mask      = CNT_W'((32'd1 << exp_c) - 32'd1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      retry_q <= '0;
      att_q   <= '0;
      give_q  <= 1'b0;
    end else if (reset_frame) begin
      retry_q <= retry_limit_i;
      att_q   <= '0;
      give_q  <= 1'b0;
    end else if (coll_ok) begin
      if (retry_q == '0) begin
        retry_q <= retry_limit_i;
        att_q   <= '0;
        give_q  <= 1'b1;
      end else begin
        retry_q <= retry_q - 1'b1;
        att_q   <= att_inc;
        give_q  <= 1'b0;
      end
    end else begin
      give_q <= 1'b0;
    end
  end

  assign load_o      = coll_ok & (retry_q != '0);
  assign clear_o     = reset_frame;
  assign draw_o      = rand_i & mask;
  assign give_up_o   = give_q;
  assign retry_cnt_o = retry_q;
  assign attempts_o  = att_q;
endmodule

// File: rtl/rb_slot_timer.sv
module rb_slot_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] slot_cycles_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] slot_q, cnt_q, slot_last;

  // zero-length slot behaves as one cycle
  assign slot_last = (slot_cycles_i == '0) ? '0 : slot_cycles_i - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      slot_q <= '0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      slot_q <= '0;
    end else if (load_i) begin
      cnt_q  <= load_val_i;
      slot_q <= '0;
    end else if (cnt_q != '0) begin
      if (slot_q >= slot_last) begin
        cnt_q  <= cnt_q - 1'b1;
        slot_q <= '0;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/retry_backoff_ctrl.sv
module retry_backoff_ctrl #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned PER_W    = 4,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             coll_i,
  input  logic             tx_ok_i,
  input  logic [CNT_W-1:0] retry_limit_i,
  input  logic [PER_W-1:0] persist_i,
  input  logic [CNT_W-1:0] slot_cycles_i,
  output logic             tx_permit_o,
  output logic             give_up_o,
  output logic [CNT_W-1:0] retry_cnt_o,
  output logic [CNT_W-1:0] attempts_o,
  output logic [CNT_W-1:0] backoff_cnt_o
);
  logic [15:0]      lfsr_q;
  logic [CNT_W-1:0] rand_w, draw_w, cnt_w;
  logic             load_w, clear_w;

  rb_lfsr #(.W(16), .SEED(LFSR_SEED), .TAPS(16'hB400)) u_lfsr (
    .clk_i, .rst_ni, .state_o(lfsr_q)
  );

  generate
    if (CNT_W <= 16) begin : g_rand_narrow
      assign rand_w = lfsr_q[CNT_W-1:0];
    end else begin : g_rand_wide
      assign rand_w = {{(CNT_W-16){1'b0}}, lfsr_q};
    end
  endgenerate

  rb_retry_ctl #(.CNT_W(CNT_W), .PER_W(PER_W)) u_ctl (
    .clk_i, .rst_ni, .sof_i, .coll_i, .tx_ok_i,
    .idle_i       (cnt_w == '0),
    .retry_limit_i, .persist_i,
    .rand_i       (rand_w),
    .load_o       (load_w),
    .clear_o      (clear_w),
    .draw_o       (draw_w),
    .give_up_o, .retry_cnt_o, .attempts_o
  );

  rb_slot_timer #(.CNT_W(CNT_W)) u_slot (
    .clk_i, .rst_ni,
    .clear_i      (clear_w),
    .load_i       (load_w),
    .load_val_i   (draw_w),
    .slot_cycles_i,
    .cnt_o        (cnt_w)
  );

  assign backoff_cnt_o = cnt_w;
  assign tx_permit_o   = (cnt_w == '0);
endmodule

// File: rtl/retry_backoff_chk.sv
module retry_backoff_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sof_i,
  input logic             coll_i,
  input logic             tx_ok_i,
  input logic             tx_permit_o,
  input logic             give_up_o,
  input logic [CNT_W-1:0] retry_cnt_o,
  input logic [CNT_W-1:0] attempts_o,
  input logic [CNT_W-1:0] backoff_cnt_o
);
  assert_giveup_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    give_up_o |=> !give_up_o);

  assert_giveup_fresh_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    give_up_o |-> (attempts_o == '0) && tx_permit_o);

  assert_draw_cap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    backoff_cnt_o <= CNT_W'(1023));

  assert_countdown_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (backoff_cnt_o != '0 && !sof_i && !tx_ok_i) |=>
      (backoff_cnt_o == $past(backoff_cnt_o)) || (backoff_cnt_o == $past(backoff_cnt_o) - 1'b1));

  assert_ignore_coll_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coll_i && !tx_permit_o && !sof_i && !tx_ok_i) |=> $stable(attempts_o) && $stable(retry_cnt_o));

  assert_retry_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coll_i && tx_permit_o && retry_cnt_o != '0 && !sof_i && !tx_ok_i) |=>
      (attempts_o == $past(attempts_o) + 1'b1) && (retry_cnt_o == $past(retry_cnt_o) - 1'b1));

  assert_frame_reset_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ok_i |=> (attempts_o == '0) && tx_permit_o);
endmodule

bind retry_backoff_ctrl retry_backoff_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/retry_backoff_ctrl_tb.sv
module retry_backoff_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sof = 1'b0, coll = 1'b0, tx_ok = 1'b0;
  logic [15:0] limit = '0, slot = 16'd1;
  logic [3:0]  persist = '0;
  logic        permit, give_up;
  logic [15:0] retry_cnt, attempts, backoff;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  retry_backoff_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sof_i(sof), .coll_i(coll), .tx_ok_i(tx_ok),
    .retry_limit_i(limit), .persist_i(persist), .slot_cycles_i(slot),
    .tx_permit_o(permit), .give_up_o(give_up), .retry_cnt_o(retry_cnt),
    .attempts_o(attempts), .backoff_cnt_o(backoff)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic strobe_sof();
    sof = 1'b1; tick(); sof = 1'b0;
  endtask

  task automatic collide(output int d);
    coll = 1'b1; tick(); coll = 1'b0;
    d = int'(backoff);
  endtask

  task automatic wait_permit(input int d, input int s, input string req);
    int n = 0;
    while (!permit && n < 40000) begin tick(); n++; end
    chk(n == d * s, req, n, d * s);
  endtask

  task automatic t_reset();
    chk(permit == 1'b1, "R1 permit", int'(permit), 1);
    chk(give_up == 1'b0, "R1 give_up", int'(give_up), 0);
    chk(retry_cnt == 0 && attempts == 0 && backoff == 0, "R1 counters",
        int'(retry_cnt + attempts + backoff), 0);
  endtask

  task automatic t_sof_load();
    limit = 16'd15; strobe_sof();
    chk(retry_cnt == 15, "R2 retry load", int'(retry_cnt), 15);
    chk(attempts == 0, "R2 attempts clear", int'(attempts), 0);
  endtask

  task automatic t_backoff_timing();
    int d;
    slot = 16'd3; persist = 4'd0;
    collide(d);
    chk(retry_cnt == 14, "R3 retry dec", int'(retry_cnt), 14);
    chk(attempts == 1, "R3 attempts inc", int'(attempts), 1);
    chk(d <= 1, "R4 range e=1", d, 1);
    chk(permit == (d == 0), "R5 permit low in wait", int'(permit), int'(d == 0));
    wait_permit(d, 3, "R5 wait length p0");
    persist = 4'd2;
    collide(d);
    chk(attempts == 2, "R3 attempts inc 2", int'(attempts), 2);
    chk(d <= 15, "R4 range e=4", d, 15);
    wait_permit(d, 3, "R5 wait length p2");
  endtask

  task automatic t_persist_max();
    int d, big = 0;
    limit = 16'd20; persist = 4'd12; slot = 16'd1; strobe_sof();
    for (int i = 0; i < 8; i++) begin
      collide(d);
      chk(d <= 1023, "R4 range cap", d, 1023);
      if (d > 1) big = 1;
      wait_permit(d, 1, "R5 wait length cap");
    end
    chk(big == 1, "R4 persistence widens range", big, 1);
  endtask

  task automatic t_slot_zero();
    int d = 0, tries = 0;
    limit = 16'd20; persist = 4'd3; slot = 16'd0; strobe_sof();
    while (d == 0 && tries < 6) begin
      collide(d); tries++;
      if (d == 0) chk(permit == 1'b1, "R6 zero draw permit", int'(permit), 1);
    end
    chk(d != 0, "R6 nonzero draw found", d, 1);
    wait_permit(d, 1, "R6 zero slot as one");
  endtask

  task automatic t_ignore();
    int d = 0, tries = 0, a0, r0, b0;
    limit = 16'd20; persist = 4'd9; slot = 16'd4; strobe_sof();
    while (d < 2 && tries < 6) begin
      collide(d); tries++;
      if (d < 2) wait_permit(d, 4, "R5 wait length");
    end
    a0 = int'(attempts); r0 = int'(retry_cnt); b0 = int'(backoff);
    collide(d);
    chk(int'(attempts) == a0, "R8 attempts kept", int'(attempts), a0);
    chk(int'(retry_cnt) == r0, "R8 retry kept", int'(retry_cnt), r0);
    chk(int'(backoff) <= b0 && permit == 1'b0, "R8 countdown kept", int'(backoff), b0);
    // end this wait with a new frame
    strobe_sof();
    chk(permit == 1'b1 && backoff == 0, "R2 sof ends wait", int'(backoff), 0);
    chk(retry_cnt == 20 && attempts == 0, "R2 sof reload", int'(retry_cnt), 20);
  endtask

  task automatic t_tx_ok();
    int d = 0, tries = 0;
    limit = 16'd9; persist = 4'd9; slot = 16'd5; strobe_sof();
    while (d == 0 && tries < 6) begin collide(d); tries++; end
    chk(permit == 1'b0, "R9 in wait", int'(permit), 0);
    tx_ok = 1'b1; tick(); tx_ok = 1'b0;
    chk(permit == 1'b1 && backoff == 0, "R9 wait ended", int'(backoff), 0);
    chk(retry_cnt == 9, "R9 retry reload", int'(retry_cnt), 9);
    chk(attempts == 0, "R9 attempts clear", int'(attempts), 0);
  endtask

  task automatic t_giveup();
    int d;
    limit = 16'd2; persist = 4'd0; slot = 16'd1; strobe_sof();
    collide(d); wait_permit(d, 1, "R5 wait length");
    chk(give_up == 1'b0, "R7 no early give-up", int'(give_up), 0);
    collide(d); wait_permit(d, 1, "R5 wait length");
    chk(give_up == 1'b0 && retry_cnt == 0, "R7 budget spent", int'(retry_cnt), 0);
    collide(d);
    chk(give_up == 1'b1, "R7 give-up pulse", int'(give_up), 1);
    chk(retry_cnt == 2 && attempts == 0, "R7 state reload", int'(retry_cnt), 2);
    chk(permit == 1'b1, "R7 permit high", int'(permit), 1);
    tick();
    chk(give_up == 1'b0, "R7 pulse one cycle", int'(give_up), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_sof_load();
    t_backoff_timing();
    t_persist_max();
    t_slot_zero();
    t_ignore();
    t_tx_ok();
    t_giveup();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule